// File: doc/BRIEF.md
# Multi-Mode Down-Counting Timer

The block is an 8-bit down-counter that counts from a start value held in a reload register. It has three ways to decrement. In delay mode it decrements once per prescaled period of the system clock. In event mode it decrements once per rising edge of an external input. In pulse mode it counts prescaled periods only while that input is high. Each time the count passes from one to zero, the counter takes the start value again, raises an interrupt request for one cycle and toggles an output pin. Because the pin toggles, its frequency is half the zero-reach rate, so it can serve as a bit clock for a serial interface while the interrupt is ignored.

Software reaches the block through a small register port. Selector 0 is the control register, which holds the mode and the prescaler code. Selector 1 is the start value on write and the live count on read.

Top module: `countdown_timer`

## Requirements
- R1: After reset the count reads 0, the control register reads 0, and `irq` and `tout` are low.
- R2: Prescaler code 0 stops the timer in every mode. The count then does not change unless a start value is written.
- R3: Control bits [2:0] select the prescaler. Codes 1 to 7 divide by 4, 10, 16, 50, 64, 100 and 200. In delay mode (control bits [4:3] = 0) the count drops by one every divisor clocks.
- R4: In event mode (bits [4:3] = 1) the count drops by one for each rising edge of `ext_in`. The input passes two synchronising flops, so the change appears three clocks after the edge is sampled.
- R5: In pulse mode (bits [4:3] = 2) prescaled counting advances only while the synchronised `ext_in` is high. While it is low, the prescaler keeps its progress.
- R6: A decrement from 1 loads the start value instead of 0, and `irq` is high for exactly the following cycle.
- R7: `tout` toggles on every zero-reach and at no other time.
- R8: A start value of 0 gives 256 decrements between zero-reaches.
- R9: Writing selector 1 while stopped sets both the start value and the count at once. While running, the same write changes only the start value.
- R10: If a selector-1 write falls in the same cycle as a zero-reach, the counter loads the newly written value.
- R11: Selector 0 reads the 5-bit control value with the upper bits zero. Mode 3 behaves as delay mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_in | input | 1 | External event or gate input, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 start value |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read source: 0 control, 1 live count |
| rd_data | output | 8 | Read data |
| irq | output | 1 | One-cycle interrupt request on zero-reach |
| tout | output | 1 | Output pin toggled on each zero-reach |

## Verification
Two events can land in the same clock edge: a software write to the start value and the counter's own reload on zero-reach. The bench holds a short reload in the fastest delay mode. It watches its own model until the next edge is due to reach zero, then places a start-value write on exactly that edge. It then checks that the count shows the new value, that `irq` fires and that `tout` toggles. Every other cycle is also compared against the behavioural model, including writes made while the timer is running and while it is stopped.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
  localparam int PRE_W = 8;

  typedef enum logic [1:0] {
    MODE_DELAY = 2'd0,
    MODE_EVENT = 2'd1,
    MODE_PULSE = 2'd2,
    MODE_ALT   = 2'd3
  } tdt_mode_e;

  typedef struct packed {
    tdt_mode_e  mode;
    logic [2:0] code;
  } tdt_ctrl_t;

  // prescaler divisor for a 3-bit code; code 0 means stopped
  function automatic logic [PRE_W-1:0] presc_div(input logic [2:0] code);
    logic [PRE_W-1:0] d;
    case (code)
      3'd1: d = 8'd4;
      3'd2: d = 8'd10;
      3'd3: d = 8'd16;
      3'd4: d = 8'd50;
      3'd5: d = 8'd64;
      3'd6: d = 8'd100;
      3'd7: d = 8'd200;
      default: d = 8'd0;
    endcase
    return d;
  endfunction

  // last prescaler state before a tick
  function automatic logic [PRE_W-1:0] presc_last(input logic [2:0] code);
    return presc_div(code) - 8'd1;
  endfunction
endpackage

// File: rtl/tdt_sync_edge.sv
module tdt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level = sync_q[STAGES-1];
  assign rise  = sync_q[STAGES-1] & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R4
endmodule

// File: rtl/tdt_prescaler.sv
module tdt_prescaler
  import tdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] code,
  input  logic       active,
  input  logic       advance,
  output logic       tick
);
  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] last;

  assign last = presc_last(code);
  assign tick = active && advance && (pcnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (!active) begin
      pcnt <= '0;
    end else if (advance) begin
      pcnt <= tick ? '0 : pcnt + 8'd1;
    end
  end

  AST_PRESC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt < 8'd200); // R3
  AST_PRESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !advance) |=> (pcnt == $past(pcnt) || pcnt == '0)); // R5
endmodule

// File: rtl/tdt_count_core.sv
module tdt_count_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             stopped,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             irq,
  output logic             tout,
  output logic             zero_hit
);
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] reload_next;

  assign reload_next = load_en ? load_val : reload_q;
  assign zero_hit    = tick && (count == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      count    <= '0;
      irq      <= 1'b0;
      tout     <= 1'b0;
    end else begin
      reload_q <= reload_next;
      irq      <= zero_hit;
      if (zero_hit) tout <= ~tout;
      if (tick) count <= zero_hit ? reload_next : count - CNT_W'(1);
      else if (load_en && stopped) count <= load_val;
    end
  end

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !load_en) |=> $stable(count)); // R2
  AST_ZERO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit |=> (count == $past(reload_next))); // R10
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R6
  AST_TOUT_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (tout != $past(tout))); // R7
  AST_STOPPED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && stopped) |=> (count == $past(load_val))); // R9
endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
  import tdt_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_in,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq,
  output logic             tout
);
  localparam int CTRL_W = $bits(tdt_ctrl_t);

  tdt_ctrl_t        ctrl_q;
  logic             gate_lvl, gate_rise;
  logic             stopped, pre_active, pre_advance, pre_tick;
  logic             tick, zero_hit, load_en;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_en && !wr_sel) ctrl_q <= tdt_ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  assign stopped     = (ctrl_q.code == 3'd0);
  assign pre_active  = !stopped && (ctrl_q.mode != MODE_EVENT);
  assign pre_advance = (ctrl_q.mode != MODE_PULSE) || gate_lvl;
  assign load_en     = wr_en && wr_sel;
  assign tick        = (ctrl_q.mode == MODE_EVENT) ? (!stopped && gate_rise) : pre_tick;

  tdt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_in),
    .level(gate_lvl), .rise(gate_rise)
  );

  tdt_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .code(ctrl_q.code),
    .active(pre_active), .advance(pre_advance), .tick(pre_tick)
  );

  tdt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .stopped(stopped),
    .load_en(load_en), .load_val(wr_data), .count(count),
    .irq(irq), .tout(tout), .zero_hit(zero_hit)
  );

  assign rd_data = rd_sel ? count : {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};

  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> !stopped); // R2
  AST_IRQ_FOLLOWS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit |=> irq); // R6
endmodule

// File: tb/countdown_timer_test.sv
module countdown_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_in = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       rd_sel = 1'b1;
  logic [7:0] rd_data;
  logic       irq, tout;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural model state
  int m_code = 0, m_mode = 0, m_pc = 0;
  int m_cnt = 256, m_start = 256;
  bit m_s1 = 0, m_s2 = 0, m_s3 = 0, m_irq = 0, m_tout = 0;

  countdown_timer uut (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq), .tout(tout)
  );

  always #4 clk = ~clk;

  function automatic int divisor(int c);
    int t[8] = '{0, 4, 10, 16, 50, 64, 100, 200};
    return t[c];
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_code = 0; m_mode = 0; m_pc = 0; m_cnt = 256; m_start = 256;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_irq = 0; m_tout = 0;
    end else begin
      int d;
      bit tk;
      int ns;
      d  = divisor(m_code);
      tk = 0;
      if (m_code != 0) begin
        if (m_mode == 1)      tk = m_s2 && !m_s3;
        else if (m_mode == 2) tk = m_s2 && (m_pc >= d - 1);
        else                  tk = (m_pc >= d - 1);
      end
      if (m_code == 0 || m_mode == 1) m_pc = 0;
      else if (!(m_mode == 2 && !m_s2)) m_pc = tk ? 0 : m_pc + 1;
      ns = m_start;
      if (wr_en && wr_sel) ns = (wr_data == 0) ? 256 : int'(wr_data);
      m_irq = 0;
      if (tk) begin
        if (m_cnt == 1) begin m_cnt = ns; m_irq = 1; m_tout = !m_tout; end
        else m_cnt = m_cnt - 1;
      end else if (wr_en && wr_sel && m_code == 0) m_cnt = ns;
      m_start = ns;
      if (wr_en && !wr_sel) begin m_code = wr_data[2:0]; m_mode = wr_data[4:3]; end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_in;
    end
  end

  always @(posedge clk) begin
    #3;
    if (!done) begin
      chk(cur_req, "rd_data", int'(rd_data),
          rd_sel ? (m_cnt % 256) : (m_mode * 8 + m_code));
      chk("R6", "irq", int'(irq), int'(m_irq));
      chk("R7", "tout", int'(tout), int'(m_tout));
    end
  end

  task automatic wreg(bit sel, logic [7:0] data);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired, actual=running expected=finished");
    finish_run();
  end

  initial begin
    bit [31:0] lf = 32'h1234_5678;
    idle(3);
    chk("R1", "count after reset", int'(rd_data), 0);
    rd_sel = 0; #1;
    chk("R1", "control after reset", int'(rd_data), 0);
    chk("R1", "irq/tout after reset", int'(irq) + int'(tout), 0);
    rd_sel = 1;
    rst_n = 1;
    idle(2);

    cur_req = "R9";
    wreg(1, 8'd5);
    chk("R9", "stopped write loads count", int'(rd_data), 5);
    cur_req = "R2";
    for (int i = 0; i < 20; i++) begin ext_in = ~ext_in; idle(2); end
    chk("R2", "stopped count", int'(rd_data), 5);

    cur_req = "R3";
    wreg(0, 8'h01);
    idle(70);
    cur_req = "R9";
    wreg(1, 8'd3);
    chk("R9", "running write leaves count", int'(rd_data) != 3 ? 1 : 0, 1);
    idle(40);

    cur_req = "R3";
    for (int c = 2; c <= 7; c++) begin
      wreg(0, 8'(c));
      idle(divisor(c) * 7 + 5);
    end

    cur_req = "R8";
    wreg(0, 8'h00);
    wreg(1, 8'd0);
    chk("R8", "zero start reads 0", int'(rd_data), 0);
    wreg(0, 8'h01);
    idle(2100);

    cur_req = "R4";
    wreg(0, 8'h00);
    wreg(1, 8'd3);
    wreg(0, 8'h09);
    for (int i = 0; i < 40; i++) begin
      ext_in = 1; idle((i % 3) + 1);
      ext_in = 0; idle((i % 2) + 1);
    end
    idle(5);

    cur_req = "R5";
    wreg(0, 8'h00);
    wreg(1, 8'd4);
    wreg(0, 8'h11);
    for (int i = 0; i < 800; i++) begin
      lf = lf * 32'd1103515245 + 32'd12345;
      ext_in = lf[20] | lf[21];
      idle(1);
    end
    ext_in = 0;

    cur_req = "R11";
    wreg(0, 8'h1A);
    idle(150);

    cur_req = "R10";
    wreg(0, 8'h00);
    wreg(1, 8'd2);
    wreg(0, 8'h01);
    while (!(m_cnt == 1 && m_pc == 3)) @(negedge clk);
    wr_en = 1; wr_sel = 1; wr_data = 8'd7;
    @(negedge clk);
    wr_en = 0;
    chk("R10", "coincident write loads new value", int'(rd_data), 7);
    chk("R10", "irq on coincident reload", int'(irq), 1);
    idle(40);

    cur_req = "R11";
    wreg(0, 8'hFF);
    rd_sel = 0; #1;
    chk("R11", "control readback", int'(rd_data), 8'h1F);
    idle(3);
    rd_sel = 1;
    idle(3);
    finish_run();
  end
endmodule